// File: doc/BRIEF.md
# Display RAM Host Port

This block is the host side of a small display memory. The memory holds 2563 words of four bits each. The host has a 4-bit data bus and two active-low strobes, one for writing and one for reading. A one-cycle command pulse puts the port into address mode. The host then sends a 12-bit word address as three nibble writes. After that the port is in data mode. Each completed write stores a nibble, and each completed read returns one. After every accepted data access an internal pointer moves to the next word.

Words 0 to 2559 are plain storage: display data plus scratch space. The top three words, 2560 to 2562, are held in flip-flops and always appear on a parallel control output, for use by the display driver. Every strobe is timed in clock cycles. A low or high period shorter than a parameterised minimum sets a sticky error flag, and the access it belongs to is dropped. The strobes carry no back-pressure: the host owns the pace, and the port only judges the widths.

Top module: `lcd_ram_host_port`

## Requirements
- R1: After reset, `dout` is 0, `strobe_err` is 0, every control word reads 0, and the port waits for the first address nibble.
- R2: In address mode, three accepted write strobes load the pointer with the most significant nibble first: bits 11:8, then 7:4, then 3:0. The port then enters data mode. Read strobes in address mode leave `dout` and the pointer unchanged.
- R3: A `cmd_start` pulse puts the port back into address mode, expecting nibble 0, from any state.
- R4: In data mode, an accepted write stores `din` into the word the pointer selects, then advances the pointer by one. `din` is sampled in the clock cycle that first sees `wr_n` high again.
- R5: In data mode, `dout` takes the selected word in the first clock cycle that samples `rd_n` low. It holds that value until the next accepted falling edge. The pointer advances when `rd_n` returns high.
- R6: When the pointer advances from 2562, the next value is 0.
- R7: If a completed address load is larger than 2562, the pointer is set to 0.
- R8: Words 2560+k (k = 0..2) drive `ctrl_regs[4k+3:4k]`. Reads of those words return the same value. These bits change only in response to a write strobe.
- R9: A strobe is too short if it is sampled low on fewer than `MIN_W` clock edges, or if it was sampled high on fewer than `MIN_W` edges before it falls. A short strobe sets `strobe_err`, which stays set until reset, and its access is dropped. For a read whose low period is too short, `dout` still takes the word, but the pointer does not move. For a read whose high period is too short, `dout` is not loaded.
- R10: If `cmd_start` falls in the same cycle as a strobe's rising edge, the command wins. No word is written, no nibble is taken, and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle pulse that starts an address load |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| din | input | 4 | Host write data or address nibble |
| dout | output | 4 | Read data, held between reads |
| ctrl_regs | output | 12 | The three control words, word 2560 in bits 3:0 |
| strobe_err | output | 1 | Sticky flag for a strobe width violation |

## Verification
The collision that matters is a command pulse arriving in the same cycle that a write strobe returns high. In address mode that write would complete a nibble, and in data mode it would complete a store. The bench raises `cmd_start` on exactly that edge in both modes. It judges the outcome by reloading the address and reading the word back, and by checking that the address that follows is assembled from a fresh nibble 0. A behavioural model, built on timestamps of the strobe edges, is compared on every clock. It also covers the pointer wrap after 2562 and short strobes of both polarities.

// File: rtl/lcdh_pkg.sv
package lcdh_pkg;
  typedef enum logic {
    M_ADDR = 1'b0,
    M_DATA = 1'b1
  } lcdh_mode_e;
endpackage

// File: rtl/lcdh_strobe_mon.sv
module lcdh_strobe_mon #(
  parameter int MIN_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_n,
  output logic fall,
  output logic rise,
  output logic long_enough
);
  localparam int CW = $clog2(MIN_W + 1);

  logic          prev_q;
  logic [CW-1:0] run_q;

  assign fall        = prev_q & ~strb_n;
  assign rise        = ~prev_q & strb_n;
  assign long_enough = (run_q >= CW'(MIN_W));

  // run_q counts sampled edges spent at the current level, saturating.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      run_q  <= CW'(MIN_W);
    end else begin
      prev_q <= strb_n;
      if (strb_n != prev_q)
        run_q <= CW'(1);
      else if (run_q < CW'(MIN_W))
        run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcdh_store.sv
module lcdh_store #(
  parameter int DW         = 4,
  parameter int AW         = 12,
  parameter int DATA_WORDS = 2560,
  parameter int CTRL_WORDS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [AW-1:0]            raddr,
  output logic [DW-1:0]            rdata,
  output logic [CTRL_WORDS*DW-1:0] ctrl_o
);
  localparam int RIW = $clog2(DATA_WORDS);

  logic [DW-1:0] ram [DATA_WORDS];

  always_ff @(posedge clk) begin
    if (we && (waddr < AW'(DATA_WORDS)))
      ram[waddr[RIW-1:0]] <= wdata;
  end

  for (genvar k = 0; k < CTRL_WORDS; k++) begin : g_ctrl
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '0;
      else if (we && (waddr == AW'(DATA_WORDS + k)))
        word_q <= wdata;
    end
    assign ctrl_o[k*DW +: DW] = word_q;
  end

  always_comb begin
    rdata = '0;
    if (raddr < AW'(DATA_WORDS))
      rdata = ram[raddr[RIW-1:0]];
    for (int k = 0; k < CTRL_WORDS; k++)
      if (raddr == AW'(DATA_WORDS + k))
        rdata = ctrl_o[k*DW +: DW];
  end
endmodule

// File: rtl/lcd_ram_host_port.sv
module lcd_ram_host_port
  import lcdh_pkg::*;
#(
  parameter int DW         = 4,
  parameter int AW         = 12,
  parameter int DATA_WORDS = 2560,
  parameter int CTRL_WORDS = 3,
  parameter int MIN_W      = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_start,
  input  logic                     wr_n,
  input  logic                     rd_n,
  input  logic [DW-1:0]            din,
  output logic [DW-1:0]            dout,
  output logic [CTRL_WORDS*DW-1:0] ctrl_regs,
  output logic                     strobe_err
);
  localparam int LAST = DATA_WORDS + CTRL_WORDS - 1;
  localparam int NIB  = AW / DW;
  localparam int PW   = (NIB > 1) ? $clog2(NIB) : 1;

  logic wr_fall, wr_rise, wr_long;
  logic rd_fall, rd_rise, rd_long;

  lcdh_strobe_mon #(.MIN_W(MIN_W)) u_wr_mon (
    .clk(clk), .rst_n(rst_n), .strb_n(wr_n),
    .fall(wr_fall), .rise(wr_rise), .long_enough(wr_long)
  );

  lcdh_strobe_mon #(.MIN_W(MIN_W)) u_rd_mon (
    .clk(clk), .rst_n(rst_n), .strb_n(rd_n),
    .fall(rd_fall), .rise(rd_rise), .long_enough(rd_long)
  );

  lcdh_mode_e    mode_q;
  logic [PW-1:0] phase_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] dout_q;
  logic          err_q;
  logic          wr_void_q, rd_void_q;
  logic [DW-1:0] rdata;

  logic          wr_ok, rd_ok, rd_load, data_wr, nib_wr, step, viol;
  logic [AW-1:0] addr_nx, assembled;

  assign wr_ok   = wr_rise & wr_long & ~wr_void_q & ~cmd_start;
  assign rd_ok   = rd_rise & rd_long & ~rd_void_q & ~cmd_start & (mode_q == M_DATA);
  assign rd_load = rd_fall & rd_long & ~cmd_start & (mode_q == M_DATA);
  assign data_wr = wr_ok & (mode_q == M_DATA);
  assign nib_wr  = wr_ok & (mode_q == M_ADDR);
  assign step    = data_wr | rd_ok;
  assign viol    = ((wr_fall | wr_rise) & ~wr_long) | ((rd_fall | rd_rise) & ~rd_long);

  assign addr_nx   = (addr_q == AW'(LAST)) ? '0 : addr_q + 1'b1;
  assign assembled = {addr_q[AW-DW-1:0], din};

  lcdh_store #(
    .DW(DW), .AW(AW), .DATA_WORDS(DATA_WORDS), .CTRL_WORDS(CTRL_WORDS)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(data_wr), .waddr(addr_q), .wdata(din),
    .raddr(addr_q), .rdata(rdata), .ctrl_o(ctrl_regs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= M_ADDR;
      phase_q   <= '0;
      addr_q    <= '0;
      dout_q    <= '0;
      err_q     <= 1'b0;
      wr_void_q <= 1'b0;
      rd_void_q <= 1'b0;
    end else begin
      if (viol)    err_q     <= 1'b1;
      if (wr_fall) wr_void_q <= ~wr_long;
      if (rd_fall) rd_void_q <= ~rd_long;
      if (rd_load) dout_q    <= rdata;

      if (cmd_start) begin
        mode_q  <= M_ADDR;
        phase_q <= '0;
      end else if (nib_wr) begin
        if (phase_q == PW'(NIB - 1)) begin
          mode_q  <= M_DATA;
          phase_q <= '0;
          addr_q  <= (assembled > AW'(LAST)) ? '0 : assembled;
        end else begin
          phase_q <= phase_q + 1'b1;
          addr_q  <= assembled;
        end
      end else if (step) begin
        addr_q <= addr_nx;
      end
    end
  end

  assign dout       = dout_q;
  assign strobe_err = err_q;
endmodule

// File: rtl/lcdh_port_chk.sv
module lcdh_port_chk
  import lcdh_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 4,
  parameter int PW    = 2,
  parameter int LAST  = 2562,
  parameter int CBITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             rd_fall,
  input logic             wr_rise,
  input logic             wr_long,
  input logic             step,
  input lcdh_mode_e       mode_q,
  input logic [PW-1:0]    phase_q,
  input logic [AW-1:0]    addr_q,
  input logic [DW-1:0]    dout,
  input logic [CBITS-1:0] ctrl_regs,
  input logic             strobe_err
);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err |=> strobe_err);

  // R9
  short_low_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !wr_long) |=> strobe_err);

  // R5
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fall |=> $stable(dout));

  // R8
  ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise |=> $stable(ctrl_regs));

  // R3
  cmd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (mode_q == M_ADDR && phase_q == '0));

  // R10
  cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> $stable(ctrl_regs));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_q == M_DATA && addr_q == AW'(LAST)) |=> (addr_q == '0));

  // R7
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DATA) |-> (addr_q <= AW'(LAST)));
endmodule

bind lcd_ram_host_port lcdh_port_chk #(
  .AW(AW), .DW(DW), .PW(PW), .LAST(LAST), .CBITS(CTRL_WORDS*DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .rd_fall(rd_fall),
  .wr_rise(wr_rise), .wr_long(wr_long), .step(step), .mode_q(mode_q),
  .phase_q(phase_q), .addr_q(addr_q), .dout(dout), .ctrl_regs(ctrl_regs),
  .strobe_err(strobe_err)
);

// File: tb/lcd_ram_host_port_test.sv
module lcd_ram_host_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_W      = 4;
  localparam int TOP        = 2562;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic        wr_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [3:0]  din = '0;
  logic [3:0]  dout;
  logic [11:0] ctrl_regs;
  logic        strobe_err;

  lcd_ram_host_port #(.MIN_W(MIN_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .wr_n(wr_n), .rd_n(rd_n),
    .din(din), .dout(dout), .ctrl_regs(ctrl_regs), .strobe_err(strobe_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural model state
  logic [3:0] mem_m [0:TOP];
  int   m_addr = 0, m_phase = 0;
  bit   m_dmode = 0, m_err = 0, cmp_on = 0;
  logic [3:0] m_dout = '0;
  int   wr_last_rise = -100, rd_last_rise = -100;
  int   n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int a);
    return (a == TOP) ? 0 : a + 1;
  endfunction

  always @(negedge clk) if (cmp_on) begin
    chk("R5", int'(dout), int'(m_dout));
    chk("R9", int'(strobe_err), int'(m_err));
    chk("R8", int'(ctrl_regs), int'({mem_m[TOP], mem_m[TOP-1], mem_m[TOP-2]}));
  end

  task automatic cmd();
    @(negedge clk); cmd_start = 1'b1;
    @(posedge clk); #1; m_dmode = 0; m_phase = 0;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic wr(input logic [3:0] d, input int lo = MIN_W, input int hi = MIN_W,
                    input bit cmd_at_rise = 0);
    int ft, rt; bit hok, lok;
    repeat (hi) @(negedge clk);
    wr_n = 1'b0; din = d;
    @(posedge clk); #1; ft = cyc;
    hok = (ft - wr_last_rise) >= MIN_W;
    if (!hok) m_err = 1;
    repeat (lo) @(negedge clk);
    wr_n = 1'b1;
    if (cmd_at_rise) cmd_start = 1'b1;
    @(posedge clk); #1; rt = cyc;
    lok = (rt - ft) >= MIN_W;
    wr_last_rise = rt;
    if (!lok) m_err = 1;
    if (cmd_at_rise) begin
      m_dmode = 0; m_phase = 0;
    end else if (hok && lok) begin
      if (!m_dmode) begin
        m_addr = ((m_addr << 4) | int'(d)) & 12'hFFF;
        m_phase++;
        if (m_phase == 3) begin
          m_phase = 0; m_dmode = 1;
          if (m_addr > TOP) m_addr = 0;
        end
      end else begin
        mem_m[m_addr] = d;
        m_addr = nxt(m_addr);
      end
    end
    if (cmd_at_rise) begin
      @(negedge clk); cmd_start = 1'b0;
    end
  endtask

  task automatic rd(input int lo = MIN_W, input int hi = MIN_W);
    int ft, rt; bit hok, lok;
    repeat (hi) @(negedge clk);
    rd_n = 1'b0;
    @(posedge clk); #1; ft = cyc;
    hok = (ft - rd_last_rise) >= MIN_W;
    if (!hok) m_err = 1;
    if (hok && m_dmode) m_dout = mem_m[m_addr];
    repeat (lo) @(negedge clk);
    rd_n = 1'b1;
    @(posedge clk); #1; rt = cyc;
    lok = (rt - ft) >= MIN_W;
    rd_last_rise = rt;
    if (!lok) m_err = 1;
    if (hok && lok && m_dmode) m_addr = nxt(m_addr);
  endtask

  task automatic load(input logic [11:0] a);
    cmd();
    wr(a[11:8]); wr(a[7:4]); wr(a[3:0]);
  endtask

  initial begin
    for (int i = 0; i <= TOP; i++) mem_m[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(dout), 0);
    chk("R1", int'(strobe_err), 0);
    chk("R1", int'(ctrl_regs), 0);
    cmp_on = 1;

    // R2 / R4: address load then consecutive writes
    load(12'h064);
    wr(4'h5); wr(4'hA); wr(4'h3); wr(4'hC);
    load(12'h064);
    rd(); chk("R5", int'(dout), 5);
    rd(); chk("R5", int'(dout), 10);
    rd(); chk("R4", int'(dout), 3);
    rd(); chk("R4", int'(dout), 12);

    // R2: reads ignored during address mode
    cmd();
    rd(); chk("R2", int'(dout), 12);
    wr(4'h0); wr(4'h6); wr(4'h4);
    rd(); chk("R2", int'(dout), 5);

    // R8 control words, R6 wrap on write and read
    load(12'd2560);
    wr(4'h1); wr(4'h2); wr(4'h3);
    chk("R8", int'(ctrl_regs), 12'h321);
    wr(4'h9);
    load(12'd2561);
    rd(); chk("R8", int'(dout), 2);
    rd(); chk("R8", int'(dout), 3);
    rd(); chk("R6", int'(dout), 9);

    // R7 out-of-range load
    load(12'hFFF);
    wr(4'h7);
    load(12'h000);
    rd(); chk("R7", int'(dout), 7);

    // R10 command on the rise of a nibble write
    cmd();
    wr(4'h0);
    wr(4'hF, MIN_W, MIN_W, 1);
    wr(4'h0); wr(4'hC); wr(4'h8);
    wr(4'h6);
    load(12'h0C8);
    rd(); chk("R10", int'(dout), 6);
    // R10 command on the rise of a data write
    load(12'h0C8);
    wr(4'hE, MIN_W, MIN_W, 1);
    load(12'h0C8);
    rd(); chk("R10", int'(dout), 6);

    // R9 width violations
    load(12'd300);
    wr(4'h4); wr(4'h8);
    load(12'd300);
    rd(1, MIN_W);
    chk("R9", int'(strobe_err), 1);
    chk("R9", int'(dout), 4);
    rd(); chk("R9", int'(dout), 4);
    rd(MIN_W, 1); chk("R9", int'(dout), 4);
    rd(); chk("R9", int'(dout), 8);
    load(12'd301);
    wr(4'hB, 1, MIN_W);
    rd(); chk("R9", int'(dout), 8);
    repeat (3) @(negedge clk);
    chk("R9", int'(strobe_err), 1);

    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule